// File: doc/BRIEF.md
# System Exception Pending Controller

This block keeps the pending state of three system exceptions: the periodic timer tick (number 15), the deferred service request (number 14) and the non-maskable interrupt (number 2). Software changes that state by writing one control/state word. Each exception has a pair of bits in that word, one to set the pending state and one to clear it. The timer tick and the NMI can also be made pending by single-cycle hardware pulses. The service call (number 11) has no stored pending state here. It enters arbitration as a level request from the instruction side.

Each cycle the block arbitrates among the pending exceptions. The NMI always wins. Each configurable exception has a 2-bit priority, where 0 is the most urgent. The winning exception number, an "anything pending" flag and a "non-NMI exception pending" flag are registered and returned in the read-back word. The read-back word also carries the active exception number, which is supplied from outside. Two priority words hold the 2-bit priority fields of the configurable handlers.

Top module: `sysexc_pend_ctrl`

## Requirements
- R1: A write of the control/state word (`wr_ctl`=1) with bit 26 set makes the tick pending. The same applies to bit 28 for the deferred service and to bit 31 for the NMI. This holds even if the matching clear bit is also 1.
- R2: A pending state is cleared only when the write has 1 in the clear bit and 0 in the matching set bit. The pairs are clear 25/set 26 for the tick, clear 27/set 28 for the deferred service and clear 30/set 31 for the NMI.
- R3: Writing 0 to any set or clear bit leaves that pending state unchanged. A cycle with no write and no hardware pulse also leaves every pending state unchanged.
- R4: `hw_tick_set` and `hw_nmi_set` make the tick and the NMI pending. Each takes precedence over a software clear in the same cycle.
- R5: In `ctl_word`, bit 26 reads the tick pending state, bit 28 the deferred-service state and bit 31 the NMI state. Bits 8:0 read `act_num`. Bits 12..20 hold the pending number and bit 22 the non-NMI flag. Every other bit reads 0.
- R6: `ctl_word[20:12]` holds the number of the highest-priority pending exception, or 0 when nothing is pending. `any_pend` is 1 exactly when that number is nonzero. An active `svc_req` counts as pending exception 11.
- R7: When the NMI is pending, the reported number is 2, whatever the other states and priorities are.
- R8: Among the configurable exceptions, the lowest priority value wins. On equal values the lower exception number wins (11 before 14 before 15).
- R9: `wr_pri2` loads the service-call priority from bits 31:30. `wr_pri3` loads the deferred-service priority from bits 23:22 and the tick priority from bits 31:30. `pri2_word` and `pri3_word` return these fields at the same positions, and all their other bits read 0.
- R10: `ctl_word[22]` is 1 exactly when the tick, the deferred service or the service call is pending.
- R11: After reset, all pending states, all priorities, the pending number and both flags are 0.
- R12: The pending number and the flags reflect a write or a hardware pulse at the same clock edge that updates the pending bits. `svc_req` is sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctl | input | 1 | Write strobe for the control/state word |
| wr_pri2 | input | 1 | Write strobe for the service-call priority word |
| wr_pri3 | input | 1 | Write strobe for the deferred/tick priority word |
| wr_data | input | 32 | Write data |
| hw_tick_set | input | 1 | Hardware pulse that makes the tick pending |
| hw_nmi_set | input | 1 | Hardware pulse that makes the NMI pending |
| svc_req | input | 1 | Level request for the service call (exception 11) |
| act_num | input | 9 | Active exception number (0 = thread mode) |
| ctl_word | output | 32 | Control/state read-back word |
| pri2_word | output | 32 | Service-call priority read-back |
| pri3_word | output | 32 | Deferred/tick priority read-back |
| any_pend | output | 1 | Any exception is pending |

## Verification
The bench writes words in which both bits of a pair are 1. A design that let the clear bit win would drop a pending state that should be kept. It raises hardware pulses in the same cycle as a software clear. A design that gave the clear precedence would lose a timer tick. It programs equal priorities to test the tie-break, where a design that used the wrong comparison would report 14 or 15 in place of 11. It holds the NMI pending under every priority setting, where a broken arbiter would report a configurable number. Random words also hit the reserved bits, which must read 0.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_W    = 9;
  localparam int PRI_W    = 2;
  localparam int N_CFG    = 3;
  localparam int N_PEND   = 3;

  localparam logic [NUM_W-1:0] NMI_NUM  = 9'd2;
  localparam logic [NUM_W-1:0] SVC_NUM  = 9'd11;
  localparam logic [NUM_W-1:0] DSV_NUM  = 9'd14;
  localparam logic [NUM_W-1:0] TICK_NUM = 9'd15;

  // stored pending bits: index 0 tick, 1 deferred, 2 nmi
  localparam int IDX_TICK = 0;
  localparam int IDX_DSV  = 1;
  localparam int IDX_NMI  = 2;

  localparam int SET_TICK = 26;
  localparam int CLR_TICK = 25;
  localparam int SET_DSV  = 28;
  localparam int CLR_DSV  = 27;
  localparam int SET_NMI  = 31;
  localparam int CLR_NMI  = 30;

  localparam int NUM_LSB  = 12;
  localparam int ISR_BIT  = 22;
  localparam int PRI_HI_LSB = 30;
  localparam int PRI_MID_LSB = 22;
endpackage

// File: rtl/sysexc_pend_bit.sv
module sysexc_pend_bit (
  input  logic clk,
  input  logic rst,
  input  logic sw_we,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  output logic pend_nxt,
  output logic pend_q
);
  always_comb begin
    pend_nxt = pend_q;
    if (sw_we && sw_set)                pend_nxt = 1'b1;
    else if (sw_we && sw_clr)           pend_nxt = 1'b0;
    if (hw_set)                         pend_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_nxt;
  end
endmodule

// File: rtl/sysexc_arb.sv
module sysexc_arb
  import sysexc_pkg::*;
#(
  parameter int N = N_CFG,
  parameter int PW = PRI_W,
  parameter int NW = NUM_W
)(
  input  logic [N-1:0]          req,
  input  logic [N-1:0][PW-1:0]  pri,
  input  logic [N-1:0][NW-1:0]  num,
  input  logic                  nmi,
  output logic [NW-1:0]         win_num
);
  logic          best_vld;
  logic [PW-1:0] best_pri;
  logic [NW-1:0] best_num;

  // sources are ordered by ascending number; strict compare keeps the lower one on ties
  always_comb begin
    best_vld = 1'b0;
    best_pri = '1;
    best_num = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!best_vld || pri[i] < best_pri)) begin
        best_vld = 1'b1;
        best_pri = pri[i];
        best_num = num[i];
      end
    end
    win_num = nmi ? NW'(NMI_NUM) : best_num;
  end
endmodule

// File: rtl/sysexc_pend_ctrl.sv
module sysexc_pend_ctrl
  import sysexc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_pri2,
  input  logic              wr_pri3,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hw_tick_set,
  input  logic              hw_nmi_set,
  input  logic              svc_req,
  input  logic [NUM_W-1:0]  act_num,
  output logic [DATA_W-1:0] ctl_word,
  output logic [DATA_W-1:0] pri2_word,
  output logic [DATA_W-1:0] pri3_word,
  output logic              any_pend
);
  localparam int SET_POS [N_PEND] = '{SET_TICK, SET_DSV, SET_NMI};
  localparam int CLR_POS [N_PEND] = '{CLR_TICK, CLR_DSV, CLR_NMI};

  logic [N_PEND-1:0] hw_vec;
  logic [N_PEND-1:0] pend_nxt;
  logic [N_PEND-1:0] pend_q;

  assign hw_vec[IDX_TICK] = hw_tick_set;
  assign hw_vec[IDX_DSV]  = 1'b0;
  assign hw_vec[IDX_NMI]  = hw_nmi_set;

  for (genvar g = 0; g < N_PEND; g++) begin : g_pend
    sysexc_pend_bit u_bit (
      .clk      (clk),
      .rst      (rst),
      .sw_we    (wr_ctl),
      .sw_set   (wr_data[SET_POS[g]]),
      .sw_clr   (wr_data[CLR_POS[g]]),
      .hw_set   (hw_vec[g]),
      .pend_nxt (pend_nxt[g]),
      .pend_q   (pend_q[g])
    );
  end

  // priority registers
  logic [PRI_W-1:0] pri_svc_q, pri_dsv_q, pri_tick_q;
  logic [PRI_W-1:0] pri_svc_n, pri_dsv_n, pri_tick_n;

  always_comb begin
    pri_svc_n  = wr_pri2 ? wr_data[PRI_HI_LSB +: PRI_W]  : pri_svc_q;
    pri_dsv_n  = wr_pri3 ? wr_data[PRI_MID_LSB +: PRI_W] : pri_dsv_q;
    pri_tick_n = wr_pri3 ? wr_data[PRI_HI_LSB +: PRI_W]  : pri_tick_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_svc_q  <= '0;
      pri_dsv_q  <= '0;
      pri_tick_q <= '0;
    end else begin
      pri_svc_q  <= pri_svc_n;
      pri_dsv_q  <= pri_dsv_n;
      pri_tick_q <= pri_tick_n;
    end
  end

  // arbitration on next-state values so the status lands with the pending bits
  logic [N_CFG-1:0]             cfg_req;
  logic [N_CFG-1:0][PRI_W-1:0]  cfg_pri;
  logic [N_CFG-1:0][NUM_W-1:0]  cfg_num;
  logic [NUM_W-1:0]             win_num;

  assign cfg_req = {pend_nxt[IDX_TICK], pend_nxt[IDX_DSV], svc_req};
  assign cfg_pri = {pri_tick_n, pri_dsv_n, pri_svc_n};
  assign cfg_num = {TICK_NUM, DSV_NUM, SVC_NUM};

  sysexc_arb #(.N(N_CFG), .PW(PRI_W), .NW(NUM_W)) u_arb (
    .req     (cfg_req),
    .pri     (cfg_pri),
    .num     (cfg_num),
    .nmi     (pend_nxt[IDX_NMI]),
    .win_num (win_num)
  );

  logic [NUM_W-1:0] num_q;
  logic             isr_q;
  logic             any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
      isr_q <= 1'b0;
      any_q <= 1'b0;
    end else begin
      num_q <= win_num;
      isr_q <= |cfg_req;
      any_q <= (|cfg_req) | pend_nxt[IDX_NMI];
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[NUM_W-1:0]           = act_num;
    ctl_word[NUM_LSB +: NUM_W]    = num_q;
    ctl_word[ISR_BIT]             = isr_q;
    ctl_word[SET_TICK]            = pend_q[IDX_TICK];
    ctl_word[SET_DSV]             = pend_q[IDX_DSV];
    ctl_word[SET_NMI]             = pend_q[IDX_NMI];
    pri2_word = '0;
    pri2_word[PRI_HI_LSB +: PRI_W]  = pri_svc_q;
    pri3_word = '0;
    pri3_word[PRI_MID_LSB +: PRI_W] = pri_dsv_q;
    pri3_word[PRI_HI_LSB +: PRI_W]  = pri_tick_q;
  end

  assign any_pend = any_q;
endmodule

// File: rtl/sysexc_pend_chk.sv
module sysexc_pend_chk
  import sysexc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_ctl,
  input logic              wr_pri2,
  input logic              wr_pri3,
  input logic [DATA_W-1:0] wr_data,
  input logic              hw_tick_set,
  input logic              hw_nmi_set,
  input logic              svc_req,
  input logic [NUM_W-1:0]  act_num,
  input logic [DATA_W-1:0] ctl_word,
  input logic [DATA_W-1:0] pri2_word,
  input logic [DATA_W-1:0] pri3_word,
  input logic              any_pend
);
  // R1
  tick_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wr_data[SET_TICK]) |=> ctl_word[SET_TICK]);
  // R2
  nmi_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wr_data[CLR_NMI] && !wr_data[SET_NMI] && !hw_nmi_set) |=> !ctl_word[SET_NMI]);
  // R3
  dsv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_ctl && (wr_data[SET_DSV] || wr_data[CLR_DSV])) |=> $stable(ctl_word[SET_DSV]));
  // R4
  hw_tick_chk: assert property (@(posedge clk) disable iff (rst)
    hw_tick_set |=> ctl_word[SET_TICK]);
  // R6
  any_match_chk: assert property (@(posedge clk) disable iff (rst)
    any_pend == (ctl_word[NUM_LSB +: NUM_W] != '0));
  // R7
  nmi_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_word[SET_NMI] |-> (ctl_word[NUM_LSB +: NUM_W] == NMI_NUM));
  // R10
  isr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[SET_TICK] || ctl_word[SET_DSV]) |-> ctl_word[ISR_BIT]);
  // R9
  pri_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (pri2_word[29:0] == '0) && (pri3_word[29:24] == '0) && (pri3_word[21:0] == '0));
endmodule

bind sysexc_pend_ctrl sysexc_pend_chk u_chk (.*);

// File: tb/sim_sysexc_pend_ctrl.sv
module sim_sysexc_pend_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_ctl, wr_pri2, wr_pri3;
  logic [31:0] wr_data;
  logic        hw_tick_set, hw_nmi_set, svc_req;
  logic [8:0]  act_num;
  logic [31:0] ctl_word, pri2_word, pri3_word;
  logic        any_pend;

  int checks = 0;
  int errors = 0;

  // model state
  logic m_t, m_s, m_n;
  logic [1:0] m_p11, m_p14, m_p15;
  logic [8:0] m_num;
  logic m_isr;

  always #2 clk = ~clk;

  sysexc_pend_ctrl u0 (.*);

  function automatic logic [8:0] exp_num(logic t, logic s, logic n, logic v,
                                         logic [1:0] p11, logic [1:0] p14, logic [1:0] p15);
    logic       got = 1'b0;
    logic [1:0] bp = 2'd3;
    logic [8:0] bn = 9'd0;
    if (n) return 9'd2;
    if (v)                     begin got = 1'b1; bp = p11; bn = 9'd11; end
    if (s && (!got || p14 < bp)) begin got = 1'b1; bp = p14; bn = 9'd14; end
    if (t && (!got || p15 < bp)) begin got = 1'b1; bp = p15; bn = 9'd15; end
    return bn;
  endfunction

  function automatic logic [31:0] exp_ctl();
    logic [31:0] w = '0;
    w[8:0]   = act_num;
    w[20:12] = m_num;
    w[22]    = m_isr;
    w[26]    = m_t;
    w[28]    = m_s;
    w[31]    = m_n;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, ctl_word, exp_ctl());
    chk({req, " R9"}, pri2_word, {m_p11, 30'b0});
    chk({req, " R9"}, pri3_word, {m_p15, 6'b0, m_p14, 22'b0});
    chk({req, " R6"}, {31'b0, any_pend}, {31'b0, m_num != 9'd0});
  endtask

  // apply current inputs at the next edge, update the model, check at negedge
  task automatic step(string req);
    @(posedge clk);
    if (wr_ctl) begin
      if (wr_data[26]) m_t = 1'b1; else if (wr_data[25]) m_t = 1'b0;
      if (wr_data[28]) m_s = 1'b1; else if (wr_data[27]) m_s = 1'b0;
      if (wr_data[31]) m_n = 1'b1; else if (wr_data[30]) m_n = 1'b0;
    end
    if (hw_tick_set) m_t = 1'b1;
    if (hw_nmi_set)  m_n = 1'b1;
    if (wr_pri2) m_p11 = wr_data[31:30];
    if (wr_pri3) begin m_p14 = wr_data[23:22]; m_p15 = wr_data[31:30]; end
    m_num = exp_num(m_t, m_s, m_n, svc_req, m_p11, m_p14, m_p15);
    m_isr = m_t | m_s | svc_req;
    @(negedge clk);
    check_all(req);
    wr_ctl = 0; wr_pri2 = 0; wr_pri3 = 0; hw_tick_set = 0; hw_nmi_set = 0;
  endtask

  task automatic wctl(logic [31:0] d); wr_ctl = 1; wr_data = d; endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired R12");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; wr_ctl = 0; wr_pri2 = 0; wr_pri3 = 0; wr_data = '0;
    hw_tick_set = 0; hw_nmi_set = 0; svc_req = 0; act_num = 9'd0;
    m_t = 0; m_s = 0; m_n = 0; m_p11 = 0; m_p14 = 0; m_p15 = 0; m_num = 0; m_isr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_all("R11 reset");

    // R1 set tick, then both set and clear: set wins
    wctl(32'h0400_0000); step("R1 tick set");
    wctl(32'h0600_0000 | 32'h1800_0000); step("R1 set+clear both");
    // R3 zero write keeps state
    wctl(32'h0000_0000); step("R3 zero write");
    // R2 clear deferred only
    wctl(32'h0800_0000); step("R2 clear deferred");
    // R8 ties: all prio 0, svc requested -> 11
    svc_req = 1; wctl(32'h1000_0000); step("R8 tie lowest number");
    // R8 lower value wins: svc prio 3, tick prio 1, deferred prio 2
    wr_pri2 = 1; wr_data = 32'hC000_0000; step("R9 pri2 write");
    wr_pri3 = 1; wr_data = 32'h4080_0000; step("R8 tick beats deferred");
    // R7 NMI
    hw_nmi_set = 1; step("R7 nmi wins");
    // R4 hw set vs sw clear same cycle
    wctl(32'h4A00_0000); hw_nmi_set = 1; hw_tick_set = 1; step("R4 hw beats clear");
    // R2 clear all
    svc_req = 0; wctl(32'h4A00_0000); step("R2 clear all");
    // R5 act passthrough
    act_num = 9'h1A5; step("R5 active number");
    // R12 svc sampled at edge
    svc_req = 1; step("R12 svc sampled");
    svc_req = 0; step("R6 nothing pending");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      wr_data = $urandom();
      wr_ctl  = (k < 5);
      wr_pri2 = (k == 5);
      wr_pri3 = (k == 6);
      hw_tick_set = ($urandom_range(0, 7) == 0);
      hw_nmi_set  = ($urandom_range(0, 15) == 0);
      svc_req     = ($urandom_range(0, 3) == 0);
      act_num     = 9'($urandom());
      step("R1 R2 R3 R8 R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule